// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block keeps a position count from two encoder lines, A and B. A two-bit mode field picks how the lines are read. In full quadrature decode every edge on either line moves the count by one, so the count runs at four times the line rate. In pulse-plus-direction mode a rising A edge moves the count and B sets its direction. The other two modes count only up or only down on A, and B is ignored. For the single-line modes an edge-rate bit chooses between both edges and rising edges only.

Software reaches the block through a small register port. Writes set the mode, the edge rate, the enable, a floor value, a ceiling value and a direct load of the count. Reads return the control word with a sticky error flag, the floor, the ceiling or the live count. The count wraps between zero and the ceiling. Turning the enable on starts the count at the floor. Both encoder lines pass through a synchronizer before edge detection.

Top module: `quad_pos_counter`

## Requirements
- R1: The control word at address 0 holds enable in bit 0, edge rate in bit 1 and mode in bits 3:2. Mode 0 is quadrature, 1 is pulse-plus-direction, 2 is up-only and 3 is down-only. Reading address 0 returns the same fields, with the error flag in bit 4.
- R2: In quadrature mode each change of exactly one of A or B moves the count by one. With the state written as {A,B}, the steps 00→01→11→10→00 count up and the reverse steps count down.
- R3: In pulse-plus-direction mode only a rising edge of A moves the count. It counts up when B is high and down when B is low. A falling edge of A and any change of B leave the count unchanged.
- R4: In up-only and down-only modes B has no effect. With the edge-rate bit at 1 both edges of A count, and with it at 0 only rising edges of A count.
- R5: While enable is 0, edges on A and B leave the count unchanged.
- R6: The floor (address 1) and the ceiling (address 2) read back the values last written. After reset the ceiling is all ones and the floor and the count are zero.
- R7: A write to address 3 loads the count when the value is at most the ceiling. A larger value is refused and the count keeps its previous value. Reading address 3 returns the count.
- R8: When enable changes from 0 to 1, the count takes the floor value on the next clock.
- R9: Counting up from a count at or above the ceiling gives zero. Counting down from zero gives the ceiling.
- R10: In quadrature mode with enable set, a sample in which both A and B change gives no count and sets the sticky error flag. The flag stays set until software writes the control word with bit 4 at 1.
- R11: When a software load and a count event fall in the same cycle, the loaded value wins and the count event is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 floor, 2 ceiling, 3 count load |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| pos_count | output | 32 | Live position count |
| err_flag | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach is the collision of a software load with a count event in the same clock. A count event only appears after the encoder edge has passed the synchronizer and the previous-sample register. The bench changes B just after a falling clock edge, waits two more falling edges so the step is pending, and then raises the load strobe so that the load and the step meet on one rising edge. The wrap cases and the illegal double-change case are set up by loading the count to the ceiling, or by moving both lines between the same two clock edges.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

   typedef enum logic [1:0] {
      QPC_QUAD = 2'd0,
      QPC_DIR  = 2'd1,
      QPC_UP   = 2'd2,
      QPC_DOWN = 2'd3
   } qpc_mode_e;

   localparam logic [1:0] QPC_A_CTRL  = 2'd0;
   localparam logic [1:0] QPC_A_FLOOR = 2'd1;
   localparam logic [1:0] QPC_A_CEIL  = 2'd2;
   localparam logic [1:0] QPC_A_COUNT = 2'd3;

   localparam int QPC_CTRL_W = 5;

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("qpc_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
   import qpc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  qpc_mode_e mode_i,
   input  logic      both_i,
   input  logic      a_i,
   input  logic      b_i,
   output logic      step_o,
   output logic      up_o,
   output logic      bad_o
);

   logic a_q, b_q;
   logic a_chg, b_chg, a_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= a_i;
         b_q <= b_i;
      end
   end

   assign a_chg  = a_i ^ a_q;
   assign b_chg  = b_i ^ b_q;
   assign a_rise = a_i & ~a_q;

   always_comb begin
      step_o = 1'b0;
      up_o   = 1'b1;
      bad_o  = 1'b0;
      unique case (mode_i)
         QPC_QUAD: begin
            step_o = a_chg ^ b_chg;
            up_o   = a_q ^ b_i;
            bad_o  = a_chg & b_chg;
         end
         QPC_DIR: begin
            step_o = a_rise;
            up_o   = b_i;
         end
         QPC_UP: begin
            step_o = both_i ? a_chg : a_rise;
            up_o   = 1'b1;
         end
         QPC_DOWN: begin
            step_o = both_i ? a_chg : a_rise;
            up_o   = 1'b0;
         end
         default: ;
      endcase
   end

   // R2: an illegal quadrature sample never also yields a step
   p_bad_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bad_o |-> !step_o);

   // R3: pulse-plus-direction mode does not step on a change of B alone
   p_dir_b_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == QPC_DIR && !a_chg) |-> !step_o);

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             step_i,
   input  logic             up_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] floor_i,
   input  logic [CNT_W-1:0] ceil_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic             en_q;
   logic             en_rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc, cnt_dec;

   assign en_rise = en_i & ~en_q;
   assign cnt_inc = (cnt_q >= ceil_i) ? '0 : cnt_q + 1'b1;
   assign cnt_dec = (cnt_q == '0) ? ceil_i : cnt_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         en_q <= en_i;
         if (load_i)              cnt_q <= load_val_i;
         else if (en_rise)        cnt_q <= floor_i;
         else if (en_i && step_i) cnt_q <= up_i ? cnt_inc : cnt_dec;
      end
   end

   assign cnt_o = cnt_q;

   p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !load_i) |=> $stable(cnt_o));

   p_floor_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !en_q && !load_i) |=> cnt_o == $past(floor_i));

   p_wrap_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && en_q && !load_i && step_i && up_i && cnt_o == ceil_i)
      |=> cnt_o == '0);

   p_wrap_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && en_q && !load_i && step_i && !up_i && cnt_o == '0)
      |=> cnt_o == $past(ceil_i));

   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && en_i && step_i) |=> cnt_o == $past(load_val_i));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
   import qpc_pkg::*;
#(
   parameter int               CNT_W       = 32,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] RESET_CEIL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic [CNT_W-1:0] pos_count,
   output logic             err_flag
);

   localparam int PAD_W = CNT_W - QPC_CTRL_W;

   generate
      if (CNT_W < QPC_CTRL_W + 1) begin : g_bad_width
         $error("quad_pos_counter: CNT_W too small for the control word");
      end
   endgenerate

   logic             en_q, both_q, err_q;
   qpc_mode_e        mode_q;
   logic [CNT_W-1:0] floor_q, ceil_q;
   logic [1:0]       sync_ab;
   logic             step, up, bad;
   logic             wr_ctrl, load_req, load_ok, bad_ev;

   assign wr_ctrl  = wr_en && (wr_addr == QPC_A_CTRL);
   assign load_req = wr_en && (wr_addr == QPC_A_COUNT);
   assign load_ok  = load_req && (wr_data <= ceil_q);
   assign bad_ev   = bad && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         both_q  <= 1'b0;
         mode_q  <= QPC_QUAD;
         floor_q <= '0;
         ceil_q  <= RESET_CEIL;
      end else if (wr_en) begin
         unique case (wr_addr)
            QPC_A_CTRL: begin
               en_q   <= wr_data[0];
               both_q <= wr_data[1];
               mode_q <= qpc_mode_e'(wr_data[3:2]);
            end
            QPC_A_FLOOR: floor_q <= wr_data;
            QPC_A_CEIL:  ceil_q  <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     err_q <= 1'b0;
      else if (bad_ev)                err_q <= 1'b1;
      else if (wr_ctrl && wr_data[4]) err_q <= 1'b0;
   end

   qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({enc_a, enc_b}),
      .q_o   (sync_ab)
   );

   qpc_decode i_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_q),
      .both_i (both_q),
      .a_i    (sync_ab[1]),
      .b_i    (sync_ab[0]),
      .step_o (step),
      .up_o   (up),
      .bad_o  (bad)
   );

   qpc_counter #(.CNT_W(CNT_W)) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_q),
      .step_i     (step),
      .up_i       (up),
      .load_i     (load_ok),
      .load_val_i (wr_data),
      .floor_i    (floor_q),
      .ceil_i     (ceil_q),
      .cnt_o      (pos_count)
   );

   always_comb begin
      unique case (rd_addr)
         QPC_A_CTRL:  rd_data = {{PAD_W{1'b0}}, err_q, mode_q, both_q, en_q};
         QPC_A_FLOOR: rd_data = floor_q;
         QPC_A_CEIL:  rd_data = ceil_q;
         default:     rd_data = pos_count;
      endcase
   end

   assign err_flag = err_q;

   p_load_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |=> pos_count == $past(wr_data));

   p_load_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && wr_data > ceil_q && !en_q) |=> $stable(pos_count));

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bad_ev |=> err_flag);

   p_err_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(wr_ctrl && wr_data[4])) |=> err_flag);

endmodule

// File: tb/test_quad_pos_counter.sv
module test_quad_pos_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enc_a = 1'b0, enc_b = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data, pos_count;
   logic        err_flag;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   quad_pos_counter i_quad_pos_counter (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pos_count(pos_count), .err_flag(err_flag)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic        both;
      logic        a;
      logic        b;
      logic [31:0] exp;
   } vec_t;

   // modes: 0 quadrature, 1 pulse+direction, 2 up-only, 3 down-only
   localparam vec_t VECS [19] = '{
      '{2'd0, 1'b0, 1'b0, 1'b1, 32'd11},  // R2 00->01 up
      '{2'd0, 1'b0, 1'b1, 1'b1, 32'd12},  // R2 01->11 up
      '{2'd0, 1'b0, 1'b1, 1'b0, 32'd13},  // R2 11->10 up
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'd14},  // R2 10->00 up
      '{2'd0, 1'b0, 1'b1, 1'b0, 32'd13},  // R2 00->10 down
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'd14},  // R2 10->00 up
      '{2'd1, 1'b0, 1'b0, 1'b1, 32'd14},  // R3 B alone
      '{2'd1, 1'b0, 1'b1, 1'b1, 32'd15},  // R3 rise, B high
      '{2'd1, 1'b0, 1'b0, 1'b1, 32'd15},  // R3 fall
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'd15},  // R3 B alone
      '{2'd1, 1'b0, 1'b1, 1'b0, 32'd14},  // R3 rise, B low
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'd14},  // R3 fall
      '{2'd2, 1'b0, 1'b1, 1'b0, 32'd15},  // R4 up, rising
      '{2'd2, 1'b0, 1'b0, 1'b1, 32'd15},  // R4 fall ignored, B ignored
      '{2'd2, 1'b1, 1'b1, 1'b1, 32'd16},  // R4 both edges, rise
      '{2'd2, 1'b1, 1'b0, 1'b0, 32'd17},  // R4 both edges, fall
      '{2'd3, 1'b1, 1'b1, 1'b1, 32'd16},  // R4 down, both, rise
      '{2'd3, 1'b0, 1'b0, 1'b0, 32'd16},  // R4 down, rising only, fall
      '{2'd3, 1'b0, 1'b1, 1'b0, 32'd15}   // R4 down, rising only, rise
   };

   function automatic logic [31:0] ctrl(input logic [1:0] m, input logic both,
                                        input logic en, input logic clr);
      return {27'd0, clr, m, both, en};
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)",
                  req, act, act, exp, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic drive(input logic a, input logic b);
      @(negedge clk);
      enc_a = a; enc_b = b;
      settle();
   endtask

   initial begin
      repeat (500000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [1:0] cur_mode;
      logic       cur_both;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state: R6
      check("R6 reset count", pos_count, 32'd0);
      rd_addr = 2'd2; #1;
      check("R6 reset ceiling", rd_data, 32'hFFFF_FFFF);
      rd_addr = 2'd1; #1;
      check("R6 reset floor", rd_data, 32'd0);
      rd_addr = 2'd0; #1;
      check("R1 reset control", rd_data, 32'd0);

      reg_wr(2'd2, 32'd100);
      reg_wr(2'd1, 32'd10);
      rd_addr = 2'd2; #1;
      check("R6 ceiling readback", rd_data, 32'd100);
      rd_addr = 2'd1; #1;
      check("R6 floor readback", rd_data, 32'd10);

      reg_wr(2'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b0));
      settle();
      check("R8 enable loads floor", pos_count, 32'd10);
      rd_addr = 2'd0; #1;
      check("R1 control readback", rd_data, 32'd1);

      cur_mode = 2'd0;
      cur_both = 1'b0;
      for (int i = 0; i < 19; i++) begin
         if (VECS[i].mode != cur_mode || VECS[i].both != cur_both) begin
            cur_mode = VECS[i].mode;
            cur_both = VECS[i].both;
            reg_wr(2'd0, ctrl(cur_mode, cur_both, 1'b1, 1'b0));
            settle();
         end
         drive(VECS[i].a, VECS[i].b);
         if (VECS[i].mode == 2'd0)      check("R2 quadrature vector", pos_count, VECS[i].exp);
         else if (VECS[i].mode == 2'd1) check("R3 direction vector", pos_count, VECS[i].exp);
         else                           check("R4 single-line vector", pos_count, VECS[i].exp);
      end

      // R7: load above ceiling refused, at ceiling accepted
      reg_wr(2'd3, 32'd101);
      settle();
      check("R7 load above ceiling refused", pos_count, 32'd15);
      reg_wr(2'd3, 32'd100);
      rd_addr = 2'd3; #1;
      check("R7 load at ceiling taken", rd_data, 32'd100);

      // R9: wrap up to zero, then down to ceiling
      reg_wr(2'd0, ctrl(2'd2, 1'b0, 1'b1, 1'b0));
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      check("R9 wrap up to zero", pos_count, 32'd0);
      reg_wr(2'd0, ctrl(2'd3, 1'b0, 1'b1, 1'b0));
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      check("R9 wrap down to ceiling", pos_count, 32'd100);

      // R5: disabled holds
      reg_wr(2'd0, ctrl(2'd3, 1'b0, 1'b0, 1'b0));
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      check("R5 disabled holds count", pos_count, 32'd100);

      // R8: re-enable loads floor
      reg_wr(2'd0, ctrl(2'd2, 1'b0, 1'b1, 1'b0));
      settle();
      check("R8 re-enable loads floor", pos_count, 32'd10);

      // R10: illegal quadrature step, state {A,B}=10 -> 01
      reg_wr(2'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b0));
      settle();
      drive(1'b0, 1'b1);
      check("R10 illegal step no count", pos_count, 32'd10);
      rd_addr = 2'd0; #1;
      check("R10 error flag bit 4 set", {31'd0, rd_data[4]}, 32'd1);
      drive(1'b1, 1'b1);
      check("R10 legal step after error", pos_count, 32'd11);
      check("R10 error flag sticky", {31'd0, err_flag}, 32'd1);
      reg_wr(2'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b1));
      rd_addr = 2'd0; #1;
      check("R10 error flag cleared", {31'd0, rd_data[4]}, 32'd0);

      // R11: load meets count step (11 -> 10 would count up)
      @(negedge clk);
      enc_b = 1'b0;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'd50;
      @(negedge clk);
      wr_en = 1'b0;
      settle();
      check("R11 load wins over step", pos_count, 32'd50);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule